// File: doc/BRIEF.md
# Reward-Modulated Synaptic Weight Update Engine

This block carries out one learning step of a three-factor plasticity rule on a square matrix of small unsigned synaptic weights. Each step is launched by a single-cycle start pulse that carries a task number and the reward earned in that task. The engine keeps one expected-reward baseline per task. It subtracts that baseline from the reward to form a signed modulating factor, and then folds the reward into the baseline as an exponential moving average.

Once the factor is fixed, the engine sweeps the synapse matrix one row per clock. For each row it reads the stored weights and the digitized causal correlation values through a combinational row-wide read port. Every correlation value is offset-corrected and halved. The engine multiplies it by the factor, scales the product by a power-of-two learning rate, adds it to the weight and clamps the sum, then writes the whole row back in the same cycle. A one-cycle done pulse marks the end of the sweep.

Top module: `reward_weight_learner`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `done` and `row_we` are all low.
- R2: A start pulse seen while idle is followed, from the next cycle on, by exactly N_ROWS consecutive cycles with `row_we` high and `row_addr` counting 0,1,…,N_ROWS-1. Every row is written whatever its correlation values. `done` is then high for exactly one cycle, in the cycle after the last write.
- R3: A correlation code c is turned into the trace a = (c > CORR_OFS) ? (c − CORR_OFS) >> 1 : 0. With the default CORR_OFS of 16, any code at or below 17 gives a zero trace and leaves the weight unchanged.
- R4: The weight change is (M · a) arithmetically shifted right by LR_SHIFT, rounding toward minus infinity, where M is the signed modulating factor. The default LR_SHIFT is 4.
- R5: M equals the reward minus the task's expected reward as it stood before this step's moving-average update.
- R6: The first time a task is used, its expected reward is set to that reward, so M is 0 and no weight changes.
- R7: On every later use, the expected reward E becomes E + ((reward − E) >>> GAMMA_SHIFT), using an arithmetic, floor-rounding shift. The default GAMMA_SHIFT is 2.
- R8: An updated weight saturates to the range 0 to 63. It is never wrapped.
- R9: A start pulse that arrives while `busy` is high is ignored. It changes no baseline and does not restart the sweep.
- R10: Baselines of different tasks are independent. Using one task does not alter another task's expected reward or its first-use state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a learning step when idle |
| task_idx | input | TASK_W (5) | Task whose baseline is used, sampled with start |
| reward | input | REW_BITS (8) | Unsigned reward, sampled with start |
| busy | output | 1 | High from the cycle after an accepted start through the done cycle |
| done | output | 1 | One-cycle pulse after the last row is written |
| row_addr | output | ROW_W (5) | Row being read and written |
| row_we | output | 1 | Write strobe for `w_row_out` at `row_addr` |
| w_row_in | input | N_COLS*W_BITS (192) | Current weights of row `row_addr`, column c at bits [c*6 +: 6] |
| corr_row_in | input | N_COLS*CORR_BITS (256) | Causal correlation codes of row `row_addr`, column c at bits [c*8 +: 8] |
| w_row_out | output | N_COLS*W_BITS (192) | Updated weights of row `row_addr`, same packing |

## Verification
The expected-reward table sits behind the engine and cannot be read at the ports. The bench therefore exposes each baseline indirectly. It launches a probe step whose reward equals the value the baseline should hold, then checks that every weight in the matrix is left unchanged, because any other baseline would give a non-zero factor and move weights that have large correlation codes. The same probe shows that a start fired in the middle of a sweep left the table alone, and that a step on one task did not disturb another. Saturation at both ends is reached by preloading weights close to the limits and pairing them with full-scale correlation codes and extreme rewards.

// File: rtl/rwl_pkg.sv
package rwl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_FIN   = 2'd2
  } rwl_state_e;
endpackage

// File: rtl/rwl_baseline.sv
module rwl_baseline #(
  parameter int N_TASKS     = 32,
  parameter int REW_BITS    = 8,
  parameter int GAMMA_SHIFT = 2,
  localparam int TASK_W     = $clog2(N_TASKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       upd,
  input  logic [TASK_W-1:0]          task_idx,
  input  logic [REW_BITS-1:0]        reward,
  output logic signed [REW_BITS:0]   mod_q
);
  logic [REW_BITS-1:0]       base_q [N_TASKS];
  logic [N_TASKS-1:0]        seen_q;
  logic [REW_BITS-1:0]       cur_base;
  logic signed [REW_BITS:0]  diff;
  logic signed [REW_BITS:0]  step;
  logic [REW_BITS:0]         base_sum;
  logic [REW_BITS-1:0]       base_d;

  always_comb begin
    cur_base = seen_q[task_idx] ? base_q[task_idx] : reward;
    diff     = $signed({1'b0, reward}) - $signed({1'b0, cur_base});
    step     = diff >>> GAMMA_SHIFT;
    base_sum = {1'b0, cur_base} + step;
    base_d   = base_sum[REW_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q  <= '0;
      seen_q <= '0;
      for (int t = 0; t < N_TASKS; t++) base_q[t] <= '0;
    end else if (upd) begin
      mod_q            <= diff;
      seen_q[task_idx] <= 1'b1;
      base_q[task_idx] <= base_d;
    end
  end

  p_first_use_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !seen_q[task_idx]) |=> (mod_q == 0));

  p_factor_from_old_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && seen_q[task_idx]) |=>
      (mod_q == $signed({1'b0, $past(reward)}) - $signed({1'b0, $past(base_q[task_idx])})));
endmodule

// File: rtl/rwl_syn_lane.sv
module rwl_syn_lane #(
  parameter int W_BITS    = 6,
  parameter int CORR_BITS = 8,
  parameter int REW_BITS  = 8,
  parameter int CORR_OFS  = 16,
  parameter int LR_SHIFT  = 4,
  localparam int ADJ_W    = CORR_BITS - 1,
  localparam int PROD_W   = REW_BITS + 1 + CORR_BITS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic signed [REW_BITS:0]  mod,
  input  logic [W_BITS-1:0]         w_in,
  input  logic [CORR_BITS-1:0]      corr_in,
  output logic [W_BITS-1:0]         w_out
);
  localparam logic [CORR_BITS-1:0] OFS = CORR_BITS'(CORR_OFS);

  logic [CORR_BITS-1:0]      corr_sub;
  logic [ADJ_W-1:0]          adj;
  logic signed [PROD_W-1:0]  prod;
  logic signed [PROD_W-1:0]  delta;
  logic [PROD_W:0]           sum;

  always_comb begin
    corr_sub = corr_in - OFS;
    adj      = (corr_in > OFS) ? corr_sub[CORR_BITS-1:1] : '0;
    prod     = mod * $signed({1'b0, adj});
    delta    = prod >>> LR_SHIFT;
    sum      = {delta[PROD_W-1], delta} + {{(PROD_W+1-W_BITS){1'b0}}, w_in};
    if (sum[PROD_W])                 w_out = '0;
    else if (|sum[PROD_W-1:W_BITS])  w_out = '1;
    else                             w_out = sum[W_BITS-1:0];
  end

  p_raise_on_positive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mod[REW_BITS]) |-> (w_out >= w_in));

  p_lower_on_negative_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mod[REW_BITS]) |-> (w_out <= w_in));

  p_dead_trace_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && corr_in <= OFS + 1) |-> (w_out == w_in));
endmodule

// File: rtl/reward_weight_learner.sv
module reward_weight_learner #(
  parameter int N_ROWS      = 32,
  parameter int N_COLS      = 32,
  parameter int N_TASKS     = 32,
  parameter int W_BITS      = 6,
  parameter int CORR_BITS   = 8,
  parameter int REW_BITS    = 8,
  parameter int CORR_OFS    = 16,
  parameter int LR_SHIFT    = 4,
  parameter int GAMMA_SHIFT = 2,
  localparam int ROW_W      = $clog2(N_ROWS),
  localparam int TASK_W     = $clog2(N_TASKS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [TASK_W-1:0]             task_idx,
  input  logic [REW_BITS-1:0]           reward,
  output logic                          busy,
  output logic                          done,
  output logic [ROW_W-1:0]              row_addr,
  output logic                          row_we,
  input  logic [N_COLS*W_BITS-1:0]      w_row_in,
  input  logic [N_COLS*CORR_BITS-1:0]   corr_row_in,
  output logic [N_COLS*W_BITS-1:0]      w_row_out
);
  import rwl_pkg::*;

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(N_ROWS - 1);

  rwl_state_e               state_q, state_d;
  logic [ROW_W-1:0]         row_q, row_d;
  logic                     accept;
  logic signed [REW_BITS:0] mod_q;

  assign accept = start && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_SWEEP;
        row_d   = '0;
      end
      ST_SWEEP: begin
        row_d = row_q + ROW_W'(1);
        if (row_q == LAST_ROW) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_FIN);
  assign row_we   = (state_q == ST_SWEEP);
  assign row_addr = row_q;

  rwl_baseline #(
    .N_TASKS(N_TASKS), .REW_BITS(REW_BITS), .GAMMA_SHIFT(GAMMA_SHIFT)
  ) u_base (
    .clk(clk), .rst_n(rst_n), .upd(accept),
    .task_idx(task_idx), .reward(reward), .mod_q(mod_q)
  );

  for (genvar c = 0; c < N_COLS; c++) begin : g_lane
    rwl_syn_lane #(
      .W_BITS(W_BITS), .CORR_BITS(CORR_BITS), .REW_BITS(REW_BITS),
      .CORR_OFS(CORR_OFS), .LR_SHIFT(LR_SHIFT)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .en(row_we), .mod(mod_q),
      .w_in(w_row_in[c*W_BITS +: W_BITS]),
      .corr_in(corr_row_in[c*CORR_BITS +: CORR_BITS]),
      .w_out(w_row_out[c*W_BITS +: W_BITS])
    );
  end

  p_rows_in_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_we && row_addr != LAST_ROW) |=> (row_we && row_addr == $past(row_addr) + ROW_W'(1)));

  p_done_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_we && row_addr == LAST_ROW) |=> (done && !row_we));

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mod_q));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!row_we && !done));
endmodule

// File: tb/test_reward_weight_learner.sv
module test_reward_weight_learner;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 32, NC = 32, WB = 6, CB = 8;
  localparam int OFS = 16, LRS = 4, GS = 2;

  logic clk = 1'b0;
  logic rst_n, start, busy, done, row_we;
  logic [4:0] task_idx, row_addr;
  logic [7:0] reward;
  logic [NC*WB-1:0] w_row_in, w_row_out;
  logic [NC*CB-1:0] corr_row_in;

  logic [NC*WB-1:0] w_mem [NR];
  logic [NC*CB-1:0] c_mem [NR];
  int mdl_base [32];
  bit mdl_seen [32];
  int exp_w [NR][NC];

  int total = 0, bad = 0;
  int wr_cnt, order_err, done_cnt, next_row;

  always #(CLK_PERIOD/2) clk = ~clk;

  reward_weight_learner i_reward_weight_learner (
    .clk(clk), .rst_n(rst_n), .start(start), .task_idx(task_idx), .reward(reward),
    .busy(busy), .done(done), .row_addr(row_addr), .row_we(row_we),
    .w_row_in(w_row_in), .corr_row_in(corr_row_in), .w_row_out(w_row_out)
  );

  assign w_row_in    = w_mem[row_addr];
  assign corr_row_in = c_mem[row_addr];

  always @(posedge clk) begin
    if (row_we) begin
      if (int'(row_addr) != next_row) order_err++;
      next_row++;
      wr_cnt++;
      w_mem[row_addr] <= w_row_out;
    end
    if (done) done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int upd_w(input int w, input int c, input int m);
    int a, d, n;
    a = (c > OFS) ? ((c - OFS) >> 1) : 0;
    d = (m * a) >>> LRS;
    n = w + d;
    if (n < 0) n = 0;
    if (n > 63) n = 63;
    return n;
  endfunction

  task automatic fill(input int wmode, input int cmode);
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) begin
        w_mem[r][c*WB +: WB] = (wmode < 0) ? WB'($urandom_range(0, 63)) : WB'(wmode);
        c_mem[r][c*CB +: CB] = (cmode < 0) ? CB'($urandom_range(0, 255)) : CB'(cmode);
      end
  endtask

  // One learning step; intrude>0 fires a second start that many cycles into the sweep.
  task automatic run_iter(input int tsk, input int rew, input string req, input int intrude);
    int cur, m, mism, first_a, first_e, cyc;
    cur = mdl_seen[tsk] ? mdl_base[tsk] : rew;
    m = rew - cur;
    mdl_base[tsk] = cur + ((rew - cur) >>> GS);
    mdl_seen[tsk] = 1'b1;
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++)
        exp_w[r][c] = upd_w(int'(w_mem[r][c*WB +: WB]), int'(c_mem[r][c*CB +: CB]), m);
    @(negedge clk);
    wr_cnt = 0; order_err = 0; done_cnt = 0; next_row = 0;
    start = 1'b1; task_idx = 5'(tsk); reward = 8'(rew);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 100) begin
      if (intrude > 0 && cyc == intrude) begin
        start = 1'b1; task_idx = 5'(tsk); reward = 8'd0;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(wr_cnt == NR && order_err == 0 && done_cnt == 1, "R2",
        "row sweep writes/order errors/done pulses", wr_cnt*100 + order_err*10 + done_cnt, NR*100 + 1);
    mism = 0; first_a = 0; first_e = 0;
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++)
        if (int'(w_mem[r][c*WB +: WB]) != exp_w[r][c]) begin
          if (mism == 0) begin
            first_a = int'(w_mem[r][c*WB +: WB]);
            first_e = exp_w[r][c];
          end
          mism++;
        end
    chk(mism == 0, req, "weight matrix (first mismatching weight)", first_a, first_e);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !row_we, "R1", "busy/done/row_we in reset",
        int'(busy) + int'(done) + int'(row_we), 0);
  endtask

  task automatic t_first_visit();
    fill(-1, -1);
    run_iter(3, 100, "R6", 0);
  endtask

  task automatic t_positive();
    fill(-1, -1);
    run_iter(3, 200, "R4 R5 R3", 0);
  endtask

  task automatic t_ema_probe();
    fill(-1, 255);
    run_iter(3, mdl_base[3], "R7", 0);
  endtask

  task automatic t_negative();
    fill(-1, -1);
    run_iter(3, 50, "R4 R5", 0);
  endtask

  task automatic t_saturate();
    fill(60, 255);
    run_iter(3, 255, "R8 high", 0);
    fill(2, 255);
    run_iter(3, 0, "R8 low", 0);
  endtask

  task automatic t_offset();
    fill(-1, OFS + 1);
    run_iter(3, 255, "R3", 0);
  endtask

  task automatic t_independent();
    fill(-1, -1);
    run_iter(7, 255, "R10 first use", 0);
    fill(-1, 255);
    run_iter(3, mdl_base[3], "R10 other task kept", 0);
  endtask

  task automatic t_busy_start();
    fill(-1, -1);
    run_iter(3, 200, "R9", 5);
    fill(-1, 255);
    run_iter(3, mdl_base[3], "R9 baseline kept", 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int t = 0; t < 32; t++) begin mdl_base[t] = 0; mdl_seen[t] = 1'b0; end
    wr_cnt = 0; order_err = 0; done_cnt = 0; next_row = 0;
    fill(0, 0);
    rst_n = 1'b0; start = 1'b0; task_idx = '0; reward = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_visit();
    t_positive();
    t_ema_probe();
    t_negative();
    t_saturate();
    t_offset();
    t_independent();
    t_busy_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule